// File: doc/BRIEF.md
# GPIO Port with Sleep-Mode Input Clamp

This block is an eight-pin general-purpose I/O port. Two software-written registers set each pin's level and direction: a data register and a direction register. A data bit of 1 drives a strong high when the pin is an output, and turns on the weak pull-up when the pin is an input. Every pad input passes through a two-stage synchronizer. Software reads the second stage as the pin-read value.

In the deep sleep modes the digital input path is forced to zero ahead of the synchronizer. This stops a floating or mid-rail pad from burning power. Two kinds of pin are exempt from the clamp: pins that serve as enabled external interrupt inputs, and pins whose alternate-function input is enabled. Each pin also has an edge or level detector on its synchronized, post-clamp value. The detector sets a sticky interrupt flag whether or not that pin's interrupt is enabled. A pin that sits high through a clamping sleep therefore shows a rising edge on wake-up and sets its flag.

Top module: `gpio_sleep_port`

## Requirements
- R1: While rst_n is low, pad_oe, pad_out, pad_pu, pin_rd and irq_flag are all zero.
- R2: A cycle with dir_wr high loads dir_wdata into the direction register. From the next clock edge, pad_oe equals that register (1 = output).
- R3: A cycle with dat_wr high loads dat_wdata into the data register. Per pin, pad_out equals data AND oe, and pad_pu equals data AND NOT oe.
- R4: A pad level present before clock edge k is not yet visible on pin_rd after edge k. It is visible after edge k+1.
- R5: sleep_mode codes are 0 = active, 1 = idle, 2 = power-down, 3 = power-save and 4 = standby. Only codes 2, 3 and 4 clamp. Codes 0, 1 and 5 to 7 never clamp.
- R6: A clamped pin enters the synchronizer as 0 whatever its pad level, so pin_rd reads 0 for it.
- R7: A pin with irq_en set is never clamped.
- R8: A pin with alt_in_en set is never clamped.
- R9: irq_mode holds two bits per pin at bits [2i+1:2i]: 00 = low level, 01 = any change, 10 = falling, 11 = rising. The selected event on the synchronized value sets irq_flag one edge after pin_rd shows it, whether irq_en is set or clear.
- R10: A pin held high through a clamping sleep, with irq_en clear and rising or any-change detection, has its flag set after the clamp is released.
- R11: irq_flag bits are sticky. A 1 on a flag_clr bit clears that flag, unless the detector fires for that pin in the same cycle, in which case the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_mode | input | 3 | Current sleep-mode code from the sleep controller |
| dat_wr | input | 1 | Write strobe for the data register |
| dat_wdata | input | 8 | Data register write value |
| dir_wr | input | 1 | Write strobe for the direction register |
| dir_wdata | input | 8 | Direction register write value |
| pad_in | input | 8 | Pad input levels |
| irq_en | input | 8 | Per-pin external interrupt enable |
| irq_mode | input | 16 | Per-pin detection mode, two bits per pin |
| alt_in_en | input | 8 | Per-pin alternate-function input enable |
| flag_clr | input | 8 | Write-1-to-clear strobes for the flags |
| pad_oe | output | 8 | Pad output enables |
| pad_out | output | 8 | Pad output values |
| pad_pu | output | 8 | Pad pull-up enables |
| pin_rd | output | 8 | Synchronized pin-read value |
| irq_flag | output | 8 | Interrupt flags |

## Verification
The hardest case to reach from the ports is the wake-up flag. The pins must first be settled high and their flags cleared. A clamping mode must then hold long enough for the synchronized value to fall. The clamp must then be lifted while the interrupts stay disabled. The bench walks this sequence for each of the three clamping codes, with both rising and any-change detection. It repeats the sequence with interrupts enabled to show that the exemption suppresses the edge. All eight sleep codes are swept against the pad, enable and alternate-function patterns.

// File: rtl/gpio_sleep_pkg.sv
package gpio_sleep_pkg;

  typedef enum logic [2:0] {
    SLP_ACTIVE = 3'd0,
    SLP_IDLE   = 3'd1,
    SLP_PDOWN  = 3'd2,
    SLP_PSAVE  = 3'd3,
    SLP_STBY   = 3'd4
  } slp_mode_e;

  typedef enum logic [1:0] {
    DET_LOW  = 2'd0,
    DET_ANY  = 2'd1,
    DET_FALL = 2'd2,
    DET_RISE = 2'd3
  } det_mode_e;

  // True when the sleep code forces the digital inputs low.
  function automatic logic mode_clamps(input logic [2:0] code);
    return (code == SLP_PDOWN) || (code == SLP_PSAVE) || (code == SLP_STBY);
  endfunction

  // Detector hit for one pin given previous and current synchronized samples.
  function automatic logic det_hit(input logic [1:0] m, input logic prev, input logic cur);
    logic h;
    case (m)
      DET_LOW:  h = ~cur;
      DET_ANY:  h = prev ^ cur;
      DET_FALL: h = prev & ~cur;
      default:  h = ~prev & cur;
    endcase
    return h;
  endfunction

endpackage

// File: rtl/gpio_drive_regs.sv
module gpio_drive_regs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dat_wr,
  input  logic [W-1:0] dat_wdata,
  input  logic         dir_wr,
  input  logic [W-1:0] dir_wdata,
  output logic [W-1:0] data_q,
  output logic [W-1:0] dir_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      if (dat_wr) data_q <= dat_wdata;
      if (dir_wr) dir_q  <= dir_wdata;
    end
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
  import gpio_sleep_pkg::*;
#(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   sleep_mode,
  input  logic [W-1:0] pad_in,
  input  logic [W-1:0] irq_en,
  input  logic [W-1:0] alt_in_en,
  output logic [W-1:0] clamp_vec,
  output logic [W-1:0] sync_out
);

  localparam int LAST = STAGES - 1;

  logic         sleep_clamp;
  logic [W-1:0] gated;

  assign sleep_clamp = mode_clamps(sleep_mode);
  assign clamp_vec   = {W{sleep_clamp}} & ~(irq_en | alt_in_en);
  assign gated       = pad_in & ~clamp_vec;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic [LAST:0] chain;
    always_ff @(posedge clk) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[LAST-1:0], gated[i]};
    end
    assign sync_out[i] = chain[LAST];
  end

endmodule

// File: rtl/gpio_edge_flags.sv
module gpio_edge_flags
  import gpio_sleep_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   sync_in,
  input  logic [2*W-1:0] irq_mode,
  input  logic [W-1:0]   flag_clr,
  output logic [W-1:0]   hit_vec,
  output logic [W-1:0]   flags
);

  logic [W-1:0] prev_q;

  for (genvar i = 0; i < W; i++) begin : g_det
    assign hit_vec[i] = det_hit(irq_mode[2*i +: 2], prev_q[i], sync_in[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      flags  <= '0;
    end else begin
      prev_q <= sync_in;
      flags  <= (flags & ~flag_clr) | hit_vec;
    end
  end

endmodule

// File: rtl/gpio_sleep_port.sv
module gpio_sleep_port #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     sleep_mode,
  input  logic           dat_wr,
  input  logic [W-1:0]   dat_wdata,
  input  logic           dir_wr,
  input  logic [W-1:0]   dir_wdata,
  input  logic [W-1:0]   pad_in,
  input  logic [W-1:0]   irq_en,
  input  logic [2*W-1:0] irq_mode,
  input  logic [W-1:0]   alt_in_en,
  input  logic [W-1:0]   flag_clr,
  output logic [W-1:0]   pad_oe,
  output logic [W-1:0]   pad_out,
  output logic [W-1:0]   pad_pu,
  output logic [W-1:0]   pin_rd,
  output logic [W-1:0]   irq_flag
);

  logic [W-1:0] data_q;
  logic [W-1:0] dir_q;
  logic [W-1:0] clamp_vec;
  logic [W-1:0] sync_vec;
  logic [W-1:0] hit_vec;

  gpio_drive_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .dat_wr(dat_wr), .dat_wdata(dat_wdata),
    .dir_wr(dir_wr), .dir_wdata(dir_wdata),
    .data_q(data_q), .dir_q(dir_q)
  );

  gpio_in_sync #(.W(W), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .sleep_mode(sleep_mode), .pad_in(pad_in),
    .irq_en(irq_en), .alt_in_en(alt_in_en),
    .clamp_vec(clamp_vec), .sync_out(sync_vec)
  );

  gpio_edge_flags #(.W(W)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .sync_in(sync_vec), .irq_mode(irq_mode), .flag_clr(flag_clr),
    .hit_vec(hit_vec), .flags(irq_flag)
  );

  assign pad_oe  = dir_q;
  assign pad_out = data_q & dir_q;
  assign pad_pu  = data_q & ~dir_q;
  assign pin_rd  = sync_vec;

endmodule

// File: rtl/gpio_sleep_port_chk.sv
module gpio_sleep_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         dat_wr,
  input logic [W-1:0] dat_wdata,
  input logic         dir_wr,
  input logic [W-1:0] dir_wdata,
  input logic [W-1:0] pad_oe,
  input logic [W-1:0] pad_out,
  input logic [W-1:0] pad_pu,
  input logic [W-1:0] pin_rd,
  input logic [W-1:0] irq_flag,
  input logic [W-1:0] flag_clr,
  input logic [W-1:0] clamp_vec,
  input logic [W-1:0] hit_vec
);

  a_r2_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
    dir_wr |=> (pad_oe == $past(dir_wdata)));

  a_r3_drive_split: assert property (@(posedge clk) disable iff (!rst_n)
    dat_wr |=> ((pad_out == ($past(dat_wdata) & pad_oe)) &&
                (pad_pu  == ($past(dat_wdata) & ~pad_oe))));

  a_r6_clamped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(clamp_vec, 2) & pin_rd) == '0));

  a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(irq_flag) & ~$past(flag_clr)) & ~irq_flag) == '0));

  a_r9_flag_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((irq_flag & ~$past(irq_flag)) & ~$past(hit_vec)) == '0));

  a_r11_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(hit_vec) & ~irq_flag) == '0));

endmodule

bind gpio_sleep_port gpio_sleep_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .dat_wr(dat_wr), .dat_wdata(dat_wdata),
  .dir_wr(dir_wr), .dir_wdata(dir_wdata),
  .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
  .pin_rd(pin_rd), .irq_flag(irq_flag), .flag_clr(flag_clr),
  .clamp_vec(clamp_vec), .hit_vec(hit_vec)
);

// File: tb/gpio_sleep_port_tb.sv
`timescale 1ns/1ps
module gpio_sleep_port_tb;

  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [2:0]     sleep_mode;
  logic           dat_wr, dir_wr;
  logic [W-1:0]   dat_wdata, dir_wdata, pad_in, irq_en, alt_in_en, flag_clr;
  logic [2*W-1:0] irq_mode;
  logic [W-1:0]   pad_oe, pad_out, pad_pu, pin_rd, irq_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  gpio_sleep_port #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .sleep_mode(sleep_mode),
    .dat_wr(dat_wr), .dat_wdata(dat_wdata),
    .dir_wr(dir_wr), .dir_wdata(dir_wdata),
    .pad_in(pad_in), .irq_en(irq_en), .irq_mode(irq_mode),
    .alt_in_en(alt_in_en), .flag_clr(flag_clr),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
    .pin_rd(pin_rd), .irq_flag(irq_flag)
  );

  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit clamp_code(input int code);
    return (code == 2) || (code == 3) || (code == 4);
  endfunction

  function automatic logic [W-1:0] expect_flags(input int m, input logic [W-1:0] o,
                                                input logic [W-1:0] n);
    case (m)
      0:       return ~o | ~n;
      1:       return o ^ n;
      2:       return o & ~n;
      default: return ~o & n;
    endcase
  endfunction

  task automatic clear_flags();
    flag_clr = '1;
    step();
    flag_clr = '0;
  endtask

  initial begin
    #200000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] pads [4];
    rst_n = 1'b0; sleep_mode = 3'd0; dat_wr = 0; dir_wr = 0;
    dat_wdata = '0; dir_wdata = '0; pad_in = '1; irq_en = '0;
    alt_in_en = '0; flag_clr = '0; irq_mode = {W{2'b11}};
    step(3);
    // R1 reset state
    chk("R1 oe", pad_oe, '0);   chk("R1 out", pad_out, '0);
    chk("R1 pu", pad_pu, '0);   chk("R1 rd", pin_rd, '0);
    chk("R1 flag", irq_flag, '0);
    rst_n = 1'b1;
    pad_in = '0;
    step(4);
    clear_flags();

    // R2 / R3 drive sweep
    for (int d = 0; d < 256; d += 17) begin
      for (int r = 0; r < 256; r += 51) begin
        dir_wr = 1; dir_wdata = W'(r); dat_wr = 1; dat_wdata = W'(d);
        step();
        dir_wr = 0; dat_wr = 0;
        chk("R2 dir", pad_oe, W'(r));
        chk("R3 out", pad_out, W'(d & r));
        chk("R3 pu", pad_pu, W'(d & ~r));
      end
    end

    // R4 latency
    pad_in = 8'h5A; step();
    chk("R4 not yet", pin_rd, 8'h00);
    step();
    chk("R4 visible", pin_rd, 8'h5A);

    // R5 R6 R7 R8 clamp sweep over every sleep code
    for (int code = 0; code < 8; code++) begin
      for (int p = 0; p < 4; p++) begin
        logic [W-1:0] pv, ev, av, ex;
        pv = (p[0]) ? 8'hFF : 8'hC3;
        ev = (p[1]) ? 8'h0F : 8'h00;
        av = (p == 3) ? 8'h30 : ((p == 2) ? 8'h81 : 8'h00);
        sleep_mode = 3'(code); pad_in = pv; irq_en = ev; alt_in_en = av;
        step(2);
        ex = clamp_code(code) ? (pv & (ev | av)) : pv;
        chk(clamp_code(code) ? "R6 R7 R8 clamp" : "R5 no clamp", pin_rd, ex);
      end
    end
    sleep_mode = 3'd0; irq_en = '0; alt_in_en = '0; pad_in = '0;
    step(4);

    // R9 detection modes, interrupts disabled
    pads[0] = 8'h00; pads[1] = 8'hA5; pads[2] = 8'h3C; pads[3] = 8'h00;
    for (int m = 0; m < 4; m++) begin
      irq_mode = {W{2'(m)}};
      pad_in = 8'h00;
      step(4);
      clear_flags();
      for (int t = 1; t < 4; t++) begin
        pad_in = pads[t];
        step(3);
        chk("R9 mode", irq_flag, expect_flags(m, pads[t-1], pads[t]));
        clear_flags();
        step();
        // R11 clear; level mode keeps firing so set wins
        chk("R11 clear", irq_flag, (m == 0) ? ~pads[t] : 8'h00);
        clear_flags();
      end
    end

    // R10 wake-up edge from clamp release
    for (int code = 2; code <= 4; code++) begin
      for (int m = 1; m <= 3; m += 2) begin
        irq_mode = {W{2'(m)}}; irq_en = '0; sleep_mode = 3'd0; pad_in = '1;
        step(4);
        clear_flags();
        sleep_mode = 3'(code);
        step(4);
        chk("R6 asleep", pin_rd, 8'h00);
        clear_flags();
        sleep_mode = 3'd1;
        step(3);
        chk("R10 wake flag", irq_flag, 8'hFF);
      end
    end

    // R7 enabled interrupt pins see no clamp edge
    irq_mode = {W{2'b01}}; irq_en = 8'hF0; sleep_mode = 3'd0; pad_in = '1;
    step(4);
    clear_flags();
    sleep_mode = 3'd2;
    step(4);
    sleep_mode = 3'd0;
    step(4);
    chk("R7 exempt no edge", irq_flag & 8'hF0, 8'h00);
    chk("R10 others flagged", irq_flag & 8'h0F, 8'h0F);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule